// File: doc/BRIEF.md
# Random Bit Stream Bias and Lag-Product Monitor

This block watches a stream of random bits, one bit per cycle qualified by a valid strobe, and gathers statistics over a record of a fixed number of bits. It counts the ones in the record. For every lag from 1 up to a maximum lag, it also counts the positions where the current bit and the bit that many places earlier are both one. When the record is complete, the block freezes its counters and raises a pass flag if the ones count lies inside a window around one half of the record. The window is three times the square root of the record length, worked out when the block is built.

Host logic reads the frozen counters through an index-in, count-out port. That port also returns the number of bit pairs each lag had. From the ones count, the pair counts and the lag products, software can derive the bit variance p(1-p) and each correlation coefficient. No division is done in hardware. A start pulse discards whatever the block holds and opens a new record. After reset the block is already collecting a record.

Top module: `bit_stat_monitor`

## Requirements
- R1: After reset, and in the cycle after a start pulse, every counter reads zero and recordDone and biasPass are low.
- R2: Read index 0 returns the number of ones accepted in the current record.
- R3: Read index k, for 1 <= k <= MAX_LAG, returns the number of accepted bits at record position i >= k for which bit i and bit i-k are both one. Bits from an earlier or aborted record never take part.
- R4: readPairs returns RECORD_LEN for index 0 and RECORD_LEN - k for index k in 1..MAX_LAG.
- R5: done is high for exactly one cycle: the cycle after the clock edge that accepts the RECORD_LEN-th bit. recordDone goes high in that same cycle and stays high until the next start.
- R6: While recordDone is high, bits offered with bitValid high are ignored and every counter keeps its value.
- R7: biasPass is high only while recordDone is high, and only when |2*N1 - RECORD_LEN| <= 2*T. Here N1 is the ones count and T = 3*floor(sqrt(RECORD_LEN)).
- R8: A start pulse during a record discards that record. A bit offered in the same cycle as start is dropped.
- R9: A cycle with bitValid low changes no counter, whatever the value on bitIn.
- R10: A read index above MAX_LAG returns zero on both readCount and readPairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears all counters and opens a new record |
| bitValid | input | 1 | Qualifies bitIn |
| bitIn | input | 1 | Random bit under test |
| readIdx | input | $clog2(MAX_LAG+2) | 0 selects the ones count; k selects the lag-k product count |
| readCount | output | $clog2(RECORD_LEN+1) | Selected counter value |
| readPairs | output | $clog2(RECORD_LEN+1) | Number of bits or bit pairs behind the selected counter |
| done | output | 1 | One-cycle pulse when the record completes |
| recordDone | output | 1 | High while the completed record is held |
| biasPass | output | 1 | Ones count lies inside the bias window |

## Verification
A wrong history tap or a stale history bit shows up as a wrong lag-product count. The count is off at one particular read index, and this is visible as soon as the record completes. A wrong bit counter moves the done pulse by one or more cycles, or lets extra bits enter a record that should be frozen. A wrong bias window shows up as a flipped biasPass when the ones count sits exactly at the edge of the window. The bench feeds records whose ones count lies just inside and just outside that edge, and reads every index after each record.

// File: rtl/bit_stat_pkg.sv
package bit_stat_pkg;

  // Strobes sent from the control module to the datapath
  typedef struct packed {
    logic clr;   // wipe counters and history
    logic acc;   // accept bitIn this cycle
    logic hold;  // record complete, results frozen
  } statStrobes_t;

  typedef enum logic {ST_COLLECT = 1'b0, ST_HELD = 1'b1} recState_t;

  // Integer square root, floor; used only on parameters at elaboration
  function automatic int isqrt(input longint v);
    longint r;
    r = 0;
    for (int b = 20; b >= 0; b--) begin
      if ((r + (64'sd1 <<< b)) * (r + (64'sd1 <<< b)) <= v)
        r = r + (64'sd1 <<< b);
    end
    return int'(r);
  endfunction

endpackage

// File: rtl/bit_stat_ctrl.sv
module bit_stat_ctrl
  import bit_stat_pkg::*;
#(
  parameter int RECORD_LEN = 1000000,
  localparam int CW = $clog2(RECORD_LEN + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         bitValid,
  output statStrobes_t strobes,
  output logic         done
);

  localparam logic [CW-1:0] LAST_POS = CW'(RECORD_LEN - 1);

  recState_t     state;
  logic [CW-1:0] bitCnt;
  logic          accept;

  assign accept = bitValid && (state == ST_COLLECT) && !start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_COLLECT;
      bitCnt <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        state  <= ST_COLLECT;
        bitCnt <= '0;
      end else if (accept) begin
        if (bitCnt == LAST_POS) begin
          state  <= ST_HELD;
          bitCnt <= '0;
          done   <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.clr  = start;
    strobes.acc  = accept;
    strobes.hold = (state == ST_HELD);
  end

endmodule

// File: rtl/bit_stat_datapath.sv
module bit_stat_datapath
  import bit_stat_pkg::*;
#(
  parameter int RECORD_LEN = 1000000,
  parameter int MAX_LAG    = 100,
  localparam int CW = $clog2(RECORD_LEN + 1),
  localparam int IW = $clog2(MAX_LAG + 2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  statStrobes_t  strobes,
  input  logic          bitIn,
  input  logic [IW-1:0] readIdx,
  output logic [CW-1:0] readCount,
  output logic [CW-1:0] readPairs,
  output logic          biasPass
);

  // Bias window on twice the ones count: |2*N1 - N| <= 2*T
  localparam int TOL    = 3 * isqrt(longint'(RECORD_LEN));
  localparam int LO_TWO = (RECORD_LEN > 2 * TOL) ? RECORD_LEN - 2 * TOL : 0;
  localparam int HI_TWO = RECORD_LEN + 2 * TOL;

  logic [MAX_LAG-1:0]         hist;     // hist[j] = bit accepted j+1 slots ago
  logic [CW-1:0]              onesCnt;
  logic [MAX_LAG-1:0][CW-1:0] lagFlat;

  // History register, cleared at start so early taps never match
  generate
    if (MAX_LAG == 1) begin : g_hist_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             hist <= '0;
        else if (strobes.clr)  hist <= '0;
        else if (strobes.acc)  hist <= bitIn;
      end
    end else begin : g_hist_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             hist <= '0;
        else if (strobes.clr)  hist <= '0;
        else if (strobes.acc)  hist <= {hist[MAX_LAG-2:0], bitIn};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        onesCnt <= '0;
    else if (strobes.clr)             onesCnt <= '0;
    else if (strobes.acc && bitIn)    onesCnt <= onesCnt + 1'b1;
  end

  // One product counter per lag
  generate
    for (genvar k = 1; k <= MAX_LAG; k++) begin : g_lag
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                    cnt <= '0;
        else if (strobes.clr)                         cnt <= '0;
        else if (strobes.acc && bitIn && hist[k-1])   cnt <= cnt + 1'b1;
      end
      assign lagFlat[k-1] = cnt;
    end
  endgenerate

  // Read port
  always_comb begin
    readCount = '0;
    readPairs = '0;
    if (readIdx == '0) begin
      readCount = onesCnt;
      readPairs = CW'(RECORD_LEN);
    end
    for (int k = 1; k <= MAX_LAG; k++) begin
      if (readIdx == IW'(k)) begin
        readCount = lagFlat[k-1];
        readPairs = CW'(RECORD_LEN - k);
      end
    end
  end

  logic [31:0] twiceOnes;
  logic        inWindow;
  assign twiceOnes = 32'(onesCnt) << 1;
  assign inWindow  = (twiceOnes >= 32'(LO_TWO)) && (twiceOnes <= 32'(HI_TWO));
  assign biasPass  = strobes.hold && inWindow;

endmodule

// File: rtl/bit_stat_monitor.sv
module bit_stat_monitor
  import bit_stat_pkg::*;
#(
  parameter int RECORD_LEN = 1000000,
  parameter int MAX_LAG    = 100,
  localparam int CW = $clog2(RECORD_LEN + 1),
  localparam int IW = $clog2(MAX_LAG + 2)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          bitValid,
  input  logic          bitIn,
  input  logic [IW-1:0] readIdx,
  output logic [CW-1:0] readCount,
  output logic [CW-1:0] readPairs,
  output logic          done,
  output logic          recordDone,
  output logic          biasPass
);

  statStrobes_t strobes;

  bit_stat_ctrl #(.RECORD_LEN(RECORD_LEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .bitValid (bitValid),
    .strobes  (strobes),
    .done     (done)
  );

  bit_stat_datapath #(.RECORD_LEN(RECORD_LEN), .MAX_LAG(MAX_LAG)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .bitIn     (bitIn),
    .readIdx   (readIdx),
    .readCount (readCount),
    .readPairs (readPairs),
    .biasPass  (biasPass)
  );

  assign recordDone = strobes.hold;

endmodule

// File: rtl/bit_stat_monitor_chk.sv
module bit_stat_monitor_chk #(
  parameter int CW = 20,
  parameter int IW = 7
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic [IW-1:0] readIdx,
  input logic [CW-1:0] readCount,
  input logic [CW-1:0] readPairs,
  input logic          done,
  input logic          recordDone,
  input logic          biasPass
);

  p_start_clears_r1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!recordDone && !biasPass && readCount == '0));

  p_count_within_pairs_r4: assert property (@(posedge clk) disable iff (!rstN)
    readCount <= readPairs);

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_with_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> recordDone);

  p_hold_rises_with_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(recordDone) |-> done);

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    (recordDone && !start) |=> (readIdx != $past(readIdx)) || $stable(readCount));

  p_pass_needs_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    biasPass |-> recordDone);

endmodule

bind bit_stat_monitor bit_stat_monitor_chk #(.CW(CW), .IW(IW)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .readIdx    (readIdx),
  .readCount  (readCount),
  .readPairs  (readPairs),
  .done       (done),
  .recordDone (recordDone),
  .biasPass   (biasPass)
);

// File: tb/bit_stat_monitor_tb.sv
module bit_stat_monitor_tb;
  localparam int N  = 64;
  localparam int K  = 8;
  localparam int CW = $clog2(N + 1);
  localparam int IW = $clog2(K + 2);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rstN, start, bitValid, bitIn;
  logic [IW-1:0] readIdx;
  logic [CW-1:0] readCount, readPairs;
  logic          done, recordDone, biasPass;

  int checks = 0;
  int errors = 0;
  bit pat [N];

  bit_stat_monitor #(.RECORD_LEN(N), .MAX_LAG(K)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .bitValid(bitValid), .bitIn(bitIn),
    .readIdx(readIdx), .readCount(readCount), .readPairs(readPairs),
    .done(done), .recordDone(recordDone), .biasPass(biasPass)
  );

  task automatic checkVal(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int refOnes();
    int c = 0;
    for (int i = 0; i < N; i++) c += pat[i];
    return c;
  endfunction

  function automatic int refLag(int k);
    int c = 0;
    for (int i = k; i < N; i++) if (pat[i] && pat[i-k]) c++;
    return c;
  endfunction

  // R7 window: |2*N1 - N| <= 2*T with T = 3*floor(sqrt(N))
  function automatic bit refPass(int ones);
    int r = 0;
    int d;
    while ((r + 1) * (r + 1) <= N) r++;
    d = 2 * ones - N;
    if (d < 0) d = -d;
    return d <= 2 * 3 * r;
  endfunction

  task automatic pushBit(bit b);
    bitValid = 1'b1;
    bitIn    = b;
    @(negedge clk);
    bitValid = 1'b0;
  endtask

  task automatic idleCycle(bit junk);
    bitValid = 1'b0;
    bitIn    = junk;
    @(negedge clk);
  endtask

  task automatic doStart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    checkVal("R1 recordDone after start", recordDone, 0);
    checkVal("R1 biasPass after start", biasPass, 0);
  endtask

  // Reads every index and compares against the model built from pat
  task automatic checkCounters(string tag, bit zeroes);
    for (int idx = 0; idx <= K + 1; idx++) begin
      readIdx = IW'(idx);
      #1;
      if (idx == 0) begin
        checkVal({tag, " R2 ones"}, readCount, zeroes ? 0 : refOnes());
        checkVal({tag, " R4 pairs idx0"}, readPairs, N);
      end else if (idx <= K) begin
        checkVal($sformatf("%s R3 lag %0d", tag, idx), readCount, zeroes ? 0 : refLag(idx));
        checkVal($sformatf("%s R4 pairs lag %0d", tag, idx), readPairs, N - idx);
      end else begin
        checkVal({tag, " R10 count out of range"}, readCount, 0);
        checkVal({tag, " R10 pairs out of range"}, readPairs, 0);
      end
    end
    readIdx = '0;
  endtask

  // Feeds pat as one record, checks done timing, counters and bias flag
  task automatic playRecord(string tag, int idleEvery);
    for (int i = 0; i < N; i++) begin
      if (i == N - 1) begin
        checkVal({tag, " R5 no done before last bit"}, done, 0);
        checkVal({tag, " R5 recordDone before last bit"}, recordDone, 0);
      end
      pushBit(pat[i]);
      if (idleEvery > 0 && (i % idleEvery) == 0 && i != N - 1) idleCycle(1'b1); // R9
    end
    checkVal({tag, " R5 done pulse"}, done, 1);
    checkVal({tag, " R5 recordDone"}, recordDone, 1);
    checkVal({tag, " R7 biasPass"}, biasPass, refPass(refOnes()));
    checkCounters(tag, 1'b0);
    idleCycle(1'b0);
    checkVal({tag, " R5 done drops"}, done, 0);
    checkVal({tag, " R5 recordDone held"}, recordDone, 1);
  endtask

  task automatic testReset();
    checkVal("R1 recordDone at reset", recordDone, 0);
    checkVal("R1 done at reset", done, 0);
    checkVal("R1 biasPass at reset", biasPass, 0);
    checkCounters("reset", 1'b1);
  endtask

  task automatic testAllOnes();
    for (int i = 0; i < N; i++) pat[i] = 1'b1;
    playRecord("allOnes", 0);
  endtask

  task automatic testAlternating();
    for (int i = 0; i < N; i++) pat[i] = (i % 2 == 0);
    doStart();
    playRecord("alternating R9", 5);
  endtask

  task automatic testFrozen();
    for (int i = 0; i < 8; i++) begin
      pushBit(i < 5);
      checkVal("R6 no done while held", done, 0);
    end
    checkVal("R6 recordDone held", recordDone, 1);
    checkVal("R6 biasPass held", biasPass, refPass(refOnes()));
    checkCounters("R6 frozen", 1'b0);
  endtask

  task automatic testLfsr();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < N; i++) begin
      pat[i] = lfsr[0];
      lfsr = lfsr[0] ? ((lfsr >> 1) ^ 16'hB400) : (lfsr >> 1);
    end
    doStart();
    playRecord("lfsr", 3);
  endtask

  task automatic testBoundary();
    for (int i = 0; i < N; i++) pat[i] = (i < 8);
    doStart();
    playRecord("R7 edge inside", 0);
    checkVal("R7 pass at window edge", biasPass, 1);
    for (int i = 0; i < N; i++) pat[i] = (i < 7);
    doStart();
    playRecord("R7 edge outside", 0);
    checkVal("R7 fail past window edge", biasPass, 0);
  endtask

  task automatic testAbort();
    doStart();
    for (int i = 0; i < 10; i++) pushBit(1'b1);
    start = 1'b1; bitValid = 1'b1; bitIn = 1'b1;
    @(negedge clk);
    start = 1'b0; bitValid = 1'b0;
    checkVal("R8 recordDone after abort", recordDone, 0);
    for (int i = 0; i < N; i++) pat[i] = 1'b0;
    readIdx = '0; #1;
    checkVal("R8 ones cleared, same-cycle bit dropped", readCount, 0);
    playRecord("R8 zeros after abort", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; bitValid = 1'b0; bitIn = 1'b0; readIdx = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAllOnes();
    testAlternating();
    testFrozen();
    testLfsr();
    testBoundary();
    testAbort();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule